// File: doc/BRIEF.md
# Chip-Select Access Timing Controller

This block sits between a synchronous host bus and slow asynchronous parts such as parallel flash, serial-free EEPROM arrays and memory-mapped switch or indicator registers. Each of up to eight banks is described by a base address, an address mask that sets its size, a port width flag (8 or 32 bits), a wait count, a relaxed-timing flag, an extended-hold flag, a buffer-enable flag and a valid bit. A host request is decoded against the valid banks. The controller then drives that bank's chip select together with the output-enable or write-enable strobe for a programmed number of bus cycles, and ends the access with a one-bus-cycle acknowledge.

The block runs on a clock at four times the bus rate. A free-running two-bit phase counter divides each bus cycle into four quarters. This lets the write strobe be released one quarter before the strobe window closes. An external early-acknowledge input can cut an access short. An address that hits no valid bank ends with an error pulse after a fixed timeout. A read from a bank with extended hold forces one dead bus cycle before the next access is taken.

Top module: `csm_top`

## Requirements
- R1: While reset is low and right after it is released, every chip select, `oe_n`, `we_n` and `bctl_n` are high, and `ack`, `err` and `port_wide` are low.
- R2: A bank matches when its valid bit is set and `(addr ^ base) & mask` is zero. When several banks match, the lowest-numbered one is used. Invalid banks never match.
- R3: The chip select of the chosen bank (`cs_n[i]` for bank i) is low in every bus cycle of the access, starting with the first bus cycle after the request is taken, with no setup cycle. `port_wide` is high during the access when the bank is 32 bits wide.
- R4: Let W be the wait count, with 0 treated as 1. Without relaxed timing, the access lasts L = W bus cycles. `ack` is high for exactly the last of them.
- R5: With relaxed timing, the access lasts L = 2W bus cycles. The strobe is active in bus cycles floor(W/2)+1 through floor(W/2)+W (cycle 1 is the first), so the stretch is split around the strobe. Without relaxed timing, the strobe is active in all L cycles.
- R6: A read drives `oe_n` low and a write drives `we_n` low during the strobe window. In quarter 3 of the last strobe cycle, and in quarter 3 of the acknowledge cycle, `we_n` is already high. `oe_n` and `we_n` are never low together.
- R7: If `early_ack` is high at the end of an access bus cycle that is not the acknowledge cycle, the next bus cycle becomes the acknowledge cycle.
- R8: After a read from a bank with extended hold, one idle bus cycle follows in which `req` is not sampled. No idle cycle follows writes or banks without the flag.
- R9: `bctl_n` is low in every bus cycle of an access to a bank whose buffer-enable flag is set, and high otherwise.
- R10: A request that matches no valid bank asserts no chip select or strobe. It raises `err` (never together with `ack`) in the 16th bus cycle after it is taken.
- R11: `req` is sampled only at the end of an idle bus cycle. The access starts in the next bus cycle, and bank settings are captured at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at four times the bus rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request, held until ack or err |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Host address |
| early_ack | input | 1 | External acknowledge that ends the access early |
| cfg_base | input | NB*AW | Base address per bank, bank i at bits i*AW |
| cfg_mask | input | NB*AW | Address mask per bank |
| cfg_valid | input | NB | Bank valid bits |
| cfg_wide | input | NB | 1 = 32-bit port, 0 = 8-bit port |
| cfg_wait | input | NB*WW | Wait count per bank |
| cfg_relax | input | NB | Relaxed timing enable per bank |
| cfg_ehold | input | NB | Idle cycle after read, per bank |
| cfg_bctl | input | NB | Buffer-control enable per bank |
| ack | output | 1 | Access acknowledge, one bus cycle |
| err | output | 1 | No-bank timeout error, one bus cycle |
| cs_n | output | NB | Chip selects, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| bctl_n | output | 1 | Buffer control, active low |
| port_wide | output | 1 | High while a 32-bit bank is accessed |

## Verification
The assertions assume the host holds `req`, `addr` and `wr` steady from the bus cycle it raises `req` until the bus cycle after `ack` or `err`, and that the bank settings do not change while a request is pending. They also assume `early_ack` is only raised during an access. The stimulus tasks meet these assumptions: every input changes only at quarter 0 of a bus cycle, the configuration is fixed before reset is released, `req` drops only after the acknowledge or error cycle, and `early_ack` is pulsed for a single bus cycle inside an access.

// File: rtl/csm_pkg.sv
package csm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_MISS = 2'd2,
        ST_HOLD = 2'd3
    } csm_st_e;

    localparam int unsigned MISS_CYCLES = 16;
    localparam int unsigned QUARTERS    = 4;
endpackage

// File: rtl/csm_decode.sv
module csm_decode #(
    parameter int NB = 8,
    parameter int AW = 32,
    localparam int IW = $clog2(NB)
) (
    input  logic [AW-1:0]    addr,
    input  logic [NB*AW-1:0] base,
    input  logic [NB*AW-1:0] mask,
    input  logic [NB-1:0]    valid,
    output logic             hit,
    output logic [IW-1:0]    idx
);
    logic [NB-1:0] match;

    // One comparator per bank.
    for (genvar g = 0; g < NB; g++) begin : g_bank
        assign match[g] = valid[g] &&
            (((addr ^ base[g*AW +: AW]) & mask[g*AW +: AW]) == '0);
    end

    // The lowest index wins: scan from the top so that later loop passes overwrite.
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (match[i]) idx = i[IW-1:0];
        end
    end
endmodule

// File: rtl/csm_shape.sv
module csm_shape #(
    parameter int WW = 4,
    localparam int CW = (WW + 1 > 5) ? WW + 1 : 5
) (
    input  logic [WW-1:0] wait_cnt,
    input  logic          relax,
    output logic [CW-1:0] len,
    output logic [CW-1:0] str_lo,
    output logic [CW-1:0] str_hi
);
    logic [CW-1:0] weff;
    logic [CW-1:0] half;

    always_comb begin
        weff = (wait_cnt == '0) ? CW'(1) : CW'(wait_cnt);
        half = weff >> 1;
        if (relax) begin
            len    = weff << 1;
            str_lo = half + CW'(1);
            str_hi = half + weff;
        end else begin
            len    = weff;
            str_lo = CW'(1);
            str_hi = weff;
        end
    end
endmodule

// File: rtl/csm_seq.sv
module csm_seq
    import csm_pkg::*;
#(
    parameter int NB = 8,
    parameter int WW = 4,
    localparam int IW = $clog2(NB),
    localparam int CW = (WW + 1 > 5) ? WW + 1 : 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic          early_ack,
    input  logic          hit,
    input  logic [IW-1:0] idx,
    input  logic [CW-1:0] len_in,
    input  logic [CW-1:0] lo_in,
    input  logic [CW-1:0] hi_in,
    input  logic          ehold_in,
    input  logic          bctl_in,
    input  logic          wide_in,
    output logic          ack,
    output logic          err,
    output logic [NB-1:0] cs_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          bctl_n,
    output logic          port_wide
);
    typedef struct packed {
        csm_st_e       st;
        logic [1:0]    ph;
        logic [IW-1:0] bank;
        logic          wr;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
        logic [CW-1:0] lo;
        logic [CW-1:0] hi;
        logic          fin;
        logic          ehold;
        logic          bctl;
        logic          wide;
    } seq_t;

    localparam logic [1:0] LAST_Q = 2'(QUARTERS - 1);

    seq_t s_d, s_q;
    logic boundary;
    logic strobe;
    logic [CW-1:0] cnt_inc;

    assign boundary = (s_q.ph == LAST_Q);
    assign cnt_inc  = s_q.cnt + CW'(1);

    always_comb begin
        s_d    = s_q;
        s_d.ph = s_q.ph + 2'd1;
        if (boundary) begin
            unique case (s_q.st)
                ST_IDLE: begin
                    if (req) begin
                        s_d.cnt = CW'(1);
                        s_d.wr  = wr;
                        if (hit) begin
                            s_d.st    = ST_ACC;
                            s_d.bank  = idx;
                            s_d.len   = len_in;
                            s_d.lo    = lo_in;
                            s_d.hi    = hi_in;
                            s_d.fin   = (len_in == CW'(1));
                            s_d.ehold = ehold_in;
                            s_d.bctl  = bctl_in;
                            s_d.wide  = wide_in;
                        end else begin
                            s_d.st    = ST_MISS;
                            s_d.fin   = 1'b0;
                            s_d.ehold = 1'b0;
                            s_d.bctl  = 1'b0;
                            s_d.wide  = 1'b0;
                        end
                    end
                end
                ST_ACC: begin
                    if (s_q.fin) begin
                        s_d.st  = (s_q.ehold && !s_q.wr) ? ST_HOLD : ST_IDLE;
                        s_d.fin = 1'b0;
                    end else begin
                        s_d.cnt = cnt_inc;
                        s_d.fin = (cnt_inc == s_q.len) || early_ack;
                    end
                end
                ST_MISS: begin
                    if (s_q.fin) begin
                        s_d.st  = ST_IDLE;
                        s_d.fin = 1'b0;
                    end else begin
                        s_d.cnt = cnt_inc;
                        s_d.fin = (cnt_inc == CW'(MISS_CYCLES));
                    end
                end
                default: begin
                    s_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    // Outputs decoded from the registered state and the current quarter.
    always_comb begin
        cs_n = '1;
        if (s_q.st == ST_ACC) cs_n[s_q.bank] = 1'b0;
    end

    assign strobe    = (s_q.st == ST_ACC) && (s_q.cnt >= s_q.lo) && (s_q.cnt <= s_q.hi);
    assign oe_n      = !(strobe && !s_q.wr);
    assign we_n      = !(strobe && s_q.wr &&
                         !(boundary && ((s_q.cnt == s_q.hi) || s_q.fin)));
    assign ack       = (s_q.st == ST_ACC) && s_q.fin;
    assign err       = (s_q.st == ST_MISS) && s_q.fin;
    assign bctl_n    = !((s_q.st == ST_ACC) && s_q.bctl);
    assign port_wide = (s_q.st == ST_ACC) && s_q.wide;
endmodule

// File: rtl/csm_top.sv
module csm_top #(
    parameter int NB = 8,
    parameter int AW = 32,
    parameter int WW = 4,
    localparam int IW = $clog2(NB),
    localparam int CW = (WW + 1 > 5) ? WW + 1 : 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic             early_ack,
    input  logic [NB*AW-1:0] cfg_base,
    input  logic [NB*AW-1:0] cfg_mask,
    input  logic [NB-1:0]    cfg_valid,
    input  logic [NB-1:0]    cfg_wide,
    input  logic [NB*WW-1:0] cfg_wait,
    input  logic [NB-1:0]    cfg_relax,
    input  logic [NB-1:0]    cfg_ehold,
    input  logic [NB-1:0]    cfg_bctl,
    output logic             ack,
    output logic             err,
    output logic [NB-1:0]    cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             bctl_n,
    output logic             port_wide
);
    logic          hit;
    logic [IW-1:0] idx;
    logic [WW-1:0] sel_wait;
    logic [CW-1:0] len, str_lo, str_hi;

    csm_decode #(.NB(NB), .AW(AW)) u_dec (
        .addr  (addr),
        .base  (cfg_base),
        .mask  (cfg_mask),
        .valid (cfg_valid),
        .hit   (hit),
        .idx   (idx)
    );

    assign sel_wait = cfg_wait[idx*WW +: WW];

    csm_shape #(.WW(WW)) u_shape (
        .wait_cnt (sel_wait),
        .relax    (cfg_relax[idx]),
        .len      (len),
        .str_lo   (str_lo),
        .str_hi   (str_hi)
    );

    csm_seq #(.NB(NB), .WW(WW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .wr        (wr),
        .early_ack (early_ack),
        .hit       (hit),
        .idx       (idx),
        .len_in    (len),
        .lo_in     (str_lo),
        .hi_in     (str_hi),
        .ehold_in  (cfg_ehold[idx]),
        .bctl_in   (cfg_bctl[idx]),
        .wide_in   (cfg_wide[idx]),
        .ack       (ack),
        .err       (err),
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .bctl_n    (bctl_n),
        .port_wide (port_wide)
    );
endmodule

// File: rtl/csm_chk.sv
module csm_chk #(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          err,
    input logic [NB-1:0] cs_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          bctl_n,
    input logic          port_wide
);
    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R10
    ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && err));

    // R10
    err_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (&cs_n && oe_n && we_n));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R4
    ack_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !(&cs_n));

    // R4
    ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> &cs_n);

    // R9
    bctl_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bctl_n |-> !(&cs_n));

    // R3
    wide_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wide |-> !(&cs_n));
endmodule

bind csm_top csm_chk #(.NB(NB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .err       (err),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .bctl_n    (bctl_n),
    .port_wide (port_wide)
);

// File: tb/sim_csm_top.sv
module sim_csm_top;
    localparam int NB = 8;
    localparam int AW = 32;
    localparam int WW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic early_ack = 1'b0;
    logic [NB*AW-1:0] cfg_base, cfg_mask;
    logic [NB*WW-1:0] cfg_wait;
    logic [NB-1:0] cfg_valid, cfg_wide, cfg_relax, cfg_ehold, cfg_bctl;
    logic ack, err, oe_n, we_n, bctl_n, port_wide;
    logic [NB-1:0] cs_n;

    logic [31:0] b_base [NB];
    logic [31:0] b_mask [NB];
    int          b_wait [NB];
    bit          b_val [NB], b_wide [NB], b_relax [NB], b_ehold [NB], b_bctl [NB];

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  hold_pending = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            cfg_base[i*AW +: AW] = b_base[i];
            cfg_mask[i*AW +: AW] = b_mask[i];
            cfg_wait[i*WW +: WW] = WW'(b_wait[i]);
            cfg_valid[i] = b_val[i];
            cfg_wide[i]  = b_wide[i];
            cfg_relax[i] = b_relax[i];
            cfg_ehold[i] = b_ehold[i];
            cfg_bctl[i]  = b_bctl[i];
        end
    end

    csm_top #(.NB(NB), .AW(AW), .WW(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .early_ack(early_ack), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .cfg_valid(cfg_valid), .cfg_wide(cfg_wide), .cfg_wait(cfg_wait),
        .cfg_relax(cfg_relax), .cfg_ehold(cfg_ehold), .cfg_bctl(cfg_bctl),
        .ack(ack), .err(err), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .bctl_n(bctl_n), .port_wide(port_wide)
    );

    localparam logic [13:0] IDLE_V = {8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

    function automatic logic [13:0] exp_vec(int b, bit w, int c, int e, int lo, int hi, int p);
        logic [7:0] cs;
        bit st;
        if (b < 0) return IDLE_V;
        cs = 8'hFF;
        cs[b] = 1'b0;
        st = (c >= lo) && (c <= hi);
        return {cs, !(st && !w), !(st && w && !(p == 3 && (c == hi || c == e))),
                !b_bctl[b], c == e, 1'b0, b_wide[b]};
    endfunction

    task automatic compare(logic [13:0] ev, string tag, int c, int p);
        logic [13:0] got;
        got = {cs_n, oe_n, we_n, bctl_n, ack, err, port_wide};
        n_chk++;
        if (got !== ev) begin
            n_fail++;
            $display("FAIL %s cycle %0d quarter %0d actual=%h expected=%h", tag, c, p, got, ev);
        end
    endtask

    // One bus cycle: compare in each quarter, then step to the next quarter.
    task automatic bus_cycle(logic [13:0] ev0, logic [13:0] ev3, string tag, int c);
        for (int p = 0; p < 4; p++) begin
            compare((p == 3) ? ev3 : ev0, tag, c, p);
            @(negedge clk);
        end
    endtask

    task automatic access(logic [31:0] a, bit w, int early_k, string tag);
        int b, wv, len, lo, hi, e, lead;
        b = -1;
        for (int i = NB - 1; i >= 0; i--)
            if (b_val[i] && (((a ^ b_base[i]) & b_mask[i]) == 0)) b = i;
        lead = hold_pending ? 2 : 1;
        req = 1'b1; wr = w; addr = a;
        for (int i = 0; i < lead; i++) bus_cycle(IDLE_V, IDLE_V, {tag, " R8 R11 lead"}, -i);
        if (b < 0) begin
            for (int c = 1; c <= 16; c++)
                bus_cycle({IDLE_V[13:3], 1'b0, c == 16, 1'b0},
                          {IDLE_V[13:3], 1'b0, c == 16, 1'b0}, {tag, " R10 miss"}, c);
            hold_pending = 1'b0;
        end else begin
            wv = (b_wait[b] == 0) ? 1 : b_wait[b];
            if (b_relax[b]) begin len = 2 * wv; lo = wv / 2 + 1; hi = wv / 2 + wv; end
            else begin len = wv; lo = 1; hi = wv; end
            e = (early_k > 0 && early_k < len) ? early_k + 1 : len;
            for (int c = 1; c <= e; c++) begin
                early_ack = (c == early_k);
                bus_cycle(exp_vec(b, w, c, e, lo, hi, 0), exp_vec(b, w, c, e, lo, hi, 3), tag, c);
            end
            early_ack = 1'b0;
            hold_pending = !w && b_ehold[b];
        end
        req = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            b_base[i] = 32'h0; b_mask[i] = 32'h0; b_wait[i] = 1;
            b_val[i] = 0; b_wide[i] = 0; b_relax[i] = 0; b_ehold[i] = 0; b_bctl[i] = 0;
        end
        // bank 0: 4 MB wide, relaxed, extended hold, buffer enable
        b_base[0] = 32'h4000_0000; b_mask[0] = 32'hFFC0_0000; b_wait[0] = 5;
        b_val[0] = 1; b_wide[0] = 1; b_relax[0] = 1; b_ehold[0] = 1; b_bctl[0] = 1;
        // bank 1: same window, invalid
        b_base[1] = 32'h4000_0000; b_mask[1] = 32'hFFC0_0000; b_wait[1] = 2; b_wide[1] = 1;
        // bank 2: wide, short, overlaps bank 3
        b_base[2] = 32'h0000_0000; b_mask[2] = 32'hFC00_0000; b_wait[2] = 2;
        b_val[2] = 1; b_wide[2] = 1;
        b_base[3] = 32'h0000_0000; b_mask[3] = 32'hFF00_0000; b_wait[3] = 3;
        b_val[3] = 1; b_bctl[3] = 1;
        // bank 5: byte port, wait 0
        b_base[5] = 32'h8000_0000; b_mask[5] = 32'hFFFF_E000; b_wait[5] = 0;
        b_val[5] = 1; b_bctl[5] = 1;
        // bank 6: byte port, wait 5, extended hold
        b_base[6] = 32'h6000_0000; b_mask[6] = 32'hFFE0_0000; b_wait[6] = 5;
        b_val[6] = 1; b_ehold[6] = 1; b_bctl[6] = 1;
        // bank 7: single register, wait 15, relaxed
        b_base[7] = 32'hA000_0000; b_mask[7] = 32'hFFFF_FFFF; b_wait[7] = 15;
        b_val[7] = 1; b_relax[7] = 1; b_ehold[7] = 1; b_bctl[7] = 1;

        repeat (3) @(negedge clk);
        compare(IDLE_V, "R1 during reset", 0, 0);
        rst_n = 1'b1;
        compare(IDLE_V, "R1 after release", 0, 0);
        bus_cycle(IDLE_V, IDLE_V, "R1 idle", 0);

        access(32'h4012_3450, 1'b0, 0, "R3 R5 R6 relaxed read bank0");
        access(32'h6001_0000, 1'b1, 0, "R4 R6 R8 write bank6 after hold");
        access(32'h4000_0010, 1'b1, 0, "R5 R6 relaxed write bank0");
        access(32'h8000_1FFC, 1'b0, 0, "R4 wait zero read bank5");
        access(32'h0010_0000, 1'b0, 0, "R2 R9 priority read bank2");
        access(32'h0200_0000, 1'b1, 0, "R2 R4 write bank2 outside bank3");
        access(32'h6000_0004, 1'b1, 2, "R7 early ack write bank6");
        access(32'h6000_0008, 1'b0, 1, "R7 R8 early ack read bank6");
        access(32'hC000_0000, 1'b0, 0, "R10 R2 no bank after hold");
        access(32'hA000_0000, 1'b0, 0, "R5 R9 relaxed read bank7");
        access(32'hA000_0001, 1'b1, 0, "R10 single-address bank miss");
        access(32'hA000_0000, 1'b1, 4, "R7 early ack before strobe bank7");
        bus_cycle(IDLE_V, IDLE_V, "R11 idle with req low", 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1-all actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule